// File: doc/BRIEF.md
# Body-Bias Regulator Mode Transition Controller

This block is the control side of a body-bias regulator serving one voltage rail. Software sees one 32-bit register. It writes an operating-point code into the low field of that register and then sets a request bit. The controller sees the request bit go from 0 to 1 and takes a snapshot of the operating-point code at that moment. From the code it derives the regulator mode it is aiming for. It then holds a busy flag for a fixed, parameterised settling time.

When the settling time ends, three things happen on the same clock edge:
- the read-only mode status field takes the target mode;
- the busy flag drops;
- hardware clears the request bit.

Software polls the register until the request bit or the busy flag reads 0. The status field is only meaningful while busy reads 0.

The sequencer has two states.
- `SQ_IDLE` waits for a request edge. The transition *launch* (`SQ_IDLE -> SQ_RAMP`) captures the target and loads the settle counter.
- `SQ_RAMP` counts the settling time down. While the count is above zero, the *hold* transition (`SQ_RAMP -> SQ_RAMP`) decrements it. When the count reaches zero, the *retire* transition (`SQ_RAMP -> SQ_IDLE`) commits the status and clears the request.

Top module: `bbldo_ctrl`

## Requirements
- R1: After an active-high synchronous reset, the whole register reads 0. That means operating point 0, request 0, status bypass (code 0) and busy 0.
- R2: Bits 1:0 hold the operating-point code. It is writable and reads back what was written, at any time, including while a transition runs.
- R3: Bits 31:7 and bit 5 always read 0. Writes to them are ignored. Writes to the status field (bits 4:3) and to the busy flag (bit 6) are also ignored.
- R4: Writing 1 to bit 2 while it reads 0 sets it on that write's clock edge. Busy (bit 6) reads 1 from the following clock edge.
- R5: Busy stays 1 for exactly SETTLE_CYCLES clock cycles. On the edge that ends it, status takes the target mode, busy drops and bit 2 clears, all on that one edge.
- R6: Operating-point code 1 (fast) targets forward-body-bias mode, status code 2. Codes 0, 2 and 3 target bypass mode, status code 0. Status codes 1 and 3 never appear.
- R7: The target is decided by the operating-point code held when the request edge is seen. Rewriting bits 1:0 after that does not change the outcome.
- R8: While bit 2 reads 1, writes to it have no effect. Writing 1 does not restart the timer, and writing 0 neither aborts the transition nor clears the bit. Only hardware clears it.
- R9: A request whose target equals the current mode still runs the full busy period and still auto-clears bit 2.
- R10: The status field changes only on the edge where busy falls. It is held steady for the whole busy period.
- R11: A reset asserted mid-transition returns every field to its reset value, and no transition continues afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register contents |

## Verification
The timing is exercised at cycle resolution, so the bench sees the following faults:
- A design that drops busy one cycle early or late, or clears the request on a different edge from the status update, misses the exact-edge checks.
- Writes of 1 and of 0 are injected in the middle of a transition. A design that restarts the timer would stretch busy, and one that honours the zero would clear the request early.
- The operating-point code is rewritten during a transition. A design that samples it late would land in the wrong mode.
- A same-mode request and a mid-transition reset show whether the design skips "no-op" transitions or lets the sequencer run on after reset.

// File: rtl/bbldo_pkg.sv
package bbldo_pkg;

    // Operating-point select codes (bits 1:0)
    typedef enum logic [1:0] {
        OP_DEFAULT = 2'd0,
        OP_FAST    = 2'd1,
        OP_NOMINAL = 2'd2,
        OP_SLOW    = 2'd3
    } op_sel_e;

    // Regulator mode status codes (bits 4:3)
    typedef enum logic [1:0] {
        LM_BYPASS = 2'd0,
        LM_RSVD1  = 2'd1,
        LM_FBB    = 2'd2,
        LM_RSVD3  = 2'd3
    } ldo_mode_e;

    // Sequencer states
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RAMP = 1'b1
    } seq_state_e;

    // Field positions that software decodes
    localparam int SEL_LSB  = 0;
    localparam int SEL_MSB  = 1;
    localparam int REQ_BIT  = 2;
    localparam int STAT_LSB = 3;
    localparam int STAT_MSB = 4;
    localparam int BUSY_BIT = 6;
    localparam int USED_W   = 7;

    function automatic ldo_mode_e target_mode(input op_sel_e sel);
        ldo_mode_e m;
        unique case (sel)
            OP_FAST:    m = LM_FBB;
            OP_DEFAULT,
            OP_NOMINAL,
            OP_SLOW:    m = LM_BYPASS;
            default:    m = LM_BYPASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bbldo_reqedge.sv
module bbldo_reqedge (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o,
    output logic rise_o
);

    logic req_q;
    logic req_d;

    // Request bit: set by software only from 0, cleared only by hardware
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else if (clr_i) begin
            req_q <= 1'b0;
        end else if (set_i) begin
            req_q <= 1'b1;
        end
    end

    // Delayed copy for 0-to-1 edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            req_d <= 1'b0;
        end else begin
            req_d <= req_q;
        end
    end

    assign req_o  = req_q;
    assign rise_o = req_q & ~req_d;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R4

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> req_o); // R4

endmodule

// File: rtl/bbldo_seq.sv
module bbldo_seq
    import bbldo_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  op_sel_e   sel_i,
    output logic      busy_o,
    output logic      done_o,
    output ldo_mode_e mode_o
);

    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    ldo_mode_e        tgt_q;
    ldo_mode_e        mode_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: launch, hold, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_i) state_d = SQ_RAMP;
            end
            SQ_RAMP: begin
                if (cnt_zero) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // Counter, target capture and status commit
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tgt_q  <= LM_BYPASS;
            mode_q <= LM_BYPASS;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        cnt_q <= CNT_LOAD;
                        tgt_q <= target_mode(sel_i);
                    end
                end
                SQ_RAMP: begin
                    if (cnt_zero) begin
                        mode_q <= tgt_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o = (state_q == SQ_RAMP);
        done_o = (state_q == SQ_RAMP) && cnt_zero;
        mode_o = mode_q;
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LM_BYPASS) || (mode_q == LM_FBB)); // R6

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> $stable(mode_q)); // R10

    AST_IDLE_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o) |=> $stable(mode_q)); // R10

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt_q <= CNT_LOAD)); // R5

endmodule

// File: rtl/bbldo_ctrl.sv
module bbldo_ctrl
    import bbldo_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - USED_W;

    op_sel_e   sel_q;
    logic      req;
    logic      rise;
    logic      req_set;
    logic      busy;
    logic      done;
    ldo_mode_e mode;
    logic      unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DATA_W-1:REQ_BIT+1];

    // Operating-point field: always writable
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= OP_DEFAULT;
        end else if (wr_en) begin
            sel_q <= op_sel_e'(wr_data[SEL_MSB:SEL_LSB]);
        end
    end

    // Software may only raise the request bit, and only from 0
    assign req_set = wr_en && wr_data[REQ_BIT] && !req;

    bbldo_reqedge u_req (
        .clk    (clk),
        .rst    (rst),
        .set_i  (req_set),
        .clr_i  (done),
        .req_o  (req),
        .rise_o (rise)
    );

    bbldo_seq #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (rise),
        .sel_i   (sel_q),
        .busy_o  (busy),
        .done_o  (done),
        .mode_o  (mode)
    );

    assign rd_data = {{PAD_W{1'b0}}, busy, 1'b0, mode, req, sel_q};

    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        busy |-> req); // R8

    AST_REQ_HW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> ($past(busy) && !busy)); // R5

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R8

    AST_BUSY_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rise)); // R4

endmodule

// File: tb/bbldo_ctrl_test.sv
module bbldo_ctrl_test;

    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [1:0] cur_status = 2'd0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bbldo_ctrl #(.DATA_W(32), .SETTLE_CYCLES(N)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge
    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] dyn(input logic [31:0] v);
        return v & 32'h0000_005C; // busy, status, request
    endfunction

    // Full transition with an optional write injected during busy cycle inj_at
    task automatic xfer(input logic [1:0] sel, input logic [1:0] exp_st,
                        input int inj_at, input logic [31:0] inj, input string tag);
        wr({29'd0, 1'b1, sel});
        chk({tag, " R4 pending"}, dyn(rd_data), {25'd0, 1'b0, 1'b0, cur_status, 1'b1, 2'b00});
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R4 busy up"}, dyn(rd_data), {25'd0, 1'b1, 1'b0, cur_status, 1'b1, 2'b00});
        for (int k = 1; k < N; k++) begin
            if (k == inj_at) begin
                wr_en = 1'b1;
                wr_data = inj;
            end
            @(posedge clk);
            #1 wr_en = 1'b0;
            @(negedge clk);
            chk({tag, " R5 R10 hold"}, dyn(rd_data), {25'd0, 1'b1, 1'b0, cur_status, 1'b1, 2'b00});
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R5 R6 retire"}, dyn(rd_data), {25'd0, 1'b0, 1'b0, exp_st, 1'b0, 2'b00});
        cur_status = exp_st;
    endtask

    task automatic t_reset;
        chk("R1 reset value", rd_data, 32'h0);
    endtask

    task automatic t_fields;
        wr(32'hFFFF_FFFB);
        chk("R2 R3 all-ones write", rd_data, 32'h0000_0003);
        wr(32'h0000_007A);
        chk("R3 status busy reserved ignored", rd_data, 32'h0000_0002);
        wr(32'h0000_0000);
        chk("R2 sel cleared", rd_data, 32'h0);
    endtask

    task automatic t_modes;
        xfer(2'd1, 2'd2, -1, 32'h0, "fast");
        chk("R6 fast readback", rd_data, 32'h0000_0011);
        xfer(2'd2, 2'd0, -1, 32'h0, "nominal");
        xfer(2'd3, 2'd0, -1, 32'h0, "R9 slow same mode");
        xfer(2'd0, 2'd0, -1, 32'h0, "R9 default same mode");
        chk("R9 default readback", rd_data, 32'h0);
    endtask

    task automatic t_sel_capture;
        xfer(2'd1, 2'd2, 2, 32'h0000_0003, "R7 sel rewrite");
        chk("R7 R2 sel reads new", rd_data & 32'h3, 32'h3);
        xfer(2'd3, 2'd0, 3, 32'h0000_0001, "R7 sel to fast late");
    endtask

    task automatic t_no_restart_abort;
        xfer(2'd1, 2'd2, 2, 32'h0000_0005, "R8 rewrite one");
        xfer(2'd2, 2'd0, 3, 32'h0000_0000, "R8 write zero");
        chk("R8 sel zero after", rd_data, 32'h0);
    endtask

    task automatic t_pending_write;
        wr(32'h0000_0001 | 32'h4);
        wr(32'h0000_0001);
        chk("R8 zero in pending window", dyn(rd_data), {25'd0, 1'b1, 3'b000, 1'b1, 2'b00});
        repeat (N) @(posedge clk);
        @(negedge clk);
        chk("R8 R5 pending completes", rd_data, 32'h0000_0011);
        cur_status = 2'd2;
        xfer(2'd2, 2'd0, -1, 32'h0, "R4 back to back");
    endtask

    task automatic t_mid_reset;
        xfer(2'd1, 2'd2, -1, 32'h0, "pre reset");
        wr(32'h0000_0006);
        repeat (2) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R11 reset mid transition", rd_data, 32'h0);
        repeat (N + 2) @(posedge clk);
        @(negedge clk);
        chk("R11 stays idle", rd_data, 32'h0);
        cur_status = 2'd0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_modes();
        t_sel_capture();
        t_no_restart_abort();
        t_pending_write();
        t_mid_reset();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule